// File: doc/BRIEF.md
# Strap-Loaded Control Register Bank

This block is a small byte-wide register file for a board-management controller. It sits on a simple peripheral bus with an address, a select strobe and a write flag. It presents fixed identity information, board strap settings and jumper states as read-only bytes. It also holds a PLL setting byte that is seeded from straps at reset and can later be changed by software, a free scratch byte, and an LED control byte.

The LED control byte drives two CPU status lamps and four debug lamps. A mode bit in the same byte decides what drives the debug lamps. When the bit is set, they show four internal probe signals. When it is clear, they show the software-written bits.

Registers sit at word-spaced offsets. Reads return data one clock after the strobe. Writes take effect on the strobe edge.

Top module: `strap_reg_bank`

## Requirements
- R1: After reset `bus_rdata` is 0x00 and the LED byte is 0xD0. The CPU red and green lamps are therefore on, and the debug lamps follow `probe_dbg`.
- R2: A read (`bus_sel`=1, `bus_wr`=0) at a rising edge puts the addressed byte on `bus_rdata` after that edge. `bus_rdata` holds its value in every cycle with no read.
- R3: Only these byte offsets are decoded: identity 0x00, board revision 0x04, logic revision 0x08, PLL 0x0C, board config 0x10, jumpers 0x18, LED 0x1C, scratch 0x2C. Any address with bits 1:0 non-zero is unmapped.
- R4: The identity byte reads {strap_prod[1:0], 4'b0000, strap_eth_sw, strap_pcie_sw}, so the product code sits in bits 7:6.
- R5: The board revision byte reads HW_REV in bits 1:0 with zeros above. The logic revision byte reads LOGIC_REV.
- R6: The board config byte reads {3'b000, strap_redir_en, 1'b0, strap_freq[2:0]}. Frequency codes 110 and 111 are reserved, but they are passed through unchanged like any other code.
- R7: The jumper byte reads {jmp_probe, jmp_skip_srom, jmp_boot_sock, 1'b0, jmp_module_id[3:0]}.
- R8: The PLL byte captures strap_pll[6:0] while reset is held. Later strap changes do not affect it. Software writes update bits 6:0, and bit 7 always reads 0. Bits 6:4 hold the core ratio and bits 3:0 hold the system ratio.
- R9: The LED byte is writable. Bit 7 is the red lamp, bit 6 the green lamp, bit 4 the debug mode and bits 3:0 the debug lamps. Bit 5 always reads 0, and writing it has no effect.
- R10: With LED bit 4 set, `led_dbg` equals `probe_dbg`. With bit 4 clear, `led_dbg` equals LED bits 3:0 and ignores the probes.
- R11: Every lamp output is active high (1 = on). `led_cpu_red` follows LED bit 7 and `led_cpu_green` follows bit 6.
- R12: Writes to read-only, reserved or unmapped offsets change nothing. Reserved and unmapped offsets read 0x00.
- R13: The scratch byte resets to 0x00 and returns whatever was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| strap_prod | input | 2 | Product code straps |
| strap_eth_sw | input | 1 | Ethernet switch fitted |
| strap_pcie_sw | input | 1 | PCIe switch fitted |
| strap_redir_en | input | 1 | Boot redirect enable strap |
| strap_freq | input | 3 | Bus/core frequency code |
| strap_pll | input | 7 | PLL reset value |
| jmp_probe | input | 1 | Logic probe input state |
| jmp_skip_srom | input | 1 | Ignore serial ROM jumper |
| jmp_boot_sock | input | 1 | Boot from socket jumper |
| jmp_module_id | input | 4 | Rear module ID |
| probe_dbg | input | 4 | Internal debug probe signals |
| led_cpu_red | output | 1 | CPU red lamp |
| led_cpu_green | output | 1 | CPU green lamp |
| led_dbg | output | 4 | Debug lamps |

## Verification
The bench changes `strap_pll` after reset and then reads the PLL byte. A design that sampled the strap live, instead of latching it, would return the new strap value. It writes all ones to the LED and PLL bytes, so a design that stored reserved bits would read back 0xFF rather than 0xDF or 0x7F. It toggles the probes both in debug mode and in software mode, which exposes a mux that is inverted or stuck. It also writes to read-only, reserved and misaligned addresses and then reads the targets. A loose decoder would show either a corrupted byte or non-zero data at a hole.

// File: rtl/strb_pkg.sv
package strb_pkg;
   localparam int NREG = 8;
   localparam int IDX_PID  = 0;
   localparam int IDX_HWV  = 1;
   localparam int IDX_LOGV = 2;
   localparam int IDX_PLL  = 3;
   localparam int IDX_HCFG = 4;
   localparam int IDX_JMP  = 5;
   localparam int IDX_LED  = 6;
   localparam int IDX_SCR  = 7;

   localparam logic [7:0] LED_RESET = 8'hD0;
   localparam logic [7:0] LED_KEEP  = 8'hDF;
   localparam logic [7:0] PLL_KEEP  = 8'h7F;

   function automatic logic [7:0] reg_offset(input int idx);
      case (idx)
         IDX_PID:  return 8'h00;
         IDX_HWV:  return 8'h04;
         IDX_LOGV: return 8'h08;
         IDX_PLL:  return 8'h0C;
         IDX_HCFG: return 8'h10;
         IDX_JMP:  return 8'h18;
         IDX_LED:  return 8'h1C;
         default:  return 8'h2C;
      endcase
   endfunction
endpackage

// File: rtl/strb_rw_reg.sv
module strb_rw_reg #(
   parameter int         W    = 8,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= rst_val & KEEP;
      else if (we)
         q <= wdata & KEEP;
   end
endmodule

// File: rtl/strb_addr_dec.sv
module strb_addr_dec
   import strb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit
);
   for (genvar i = 0; i < NREG; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(reg_offset(i));
      assign hit[i] = (addr == OFF);
   end
endmodule

// File: rtl/strb_led_ctl.sv
module strb_led_ctl
   import strb_pkg::*;
#(
   parameter int N_DBG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       wdata,
   input  logic [N_DBG-1:0] probe,
   output logic [7:0]       q,
   output logic             led_red,
   output logic             led_green,
   output logic [N_DBG-1:0] led_dbg
);
   localparam int MODE_BIT = 4;

   if (N_DBG < 1 || N_DBG > 4) begin : g_bad_n
      $error("N_DBG must be 1..4");
   end

   strb_rw_reg #(.W(8), .KEEP(LED_KEEP)) u_reg (
      .clk(clk), .rst_n(rst_n), .rst_val(LED_RESET),
      .we(we), .wdata(wdata), .q(q)
   );

   assign led_red   = q[7];
   assign led_green = q[6];

   for (genvar i = 0; i < N_DBG; i++) begin : g_dbg
      assign led_dbg[i] = q[MODE_BIT] ? probe[i] : q[i];
   end
endmodule

// File: rtl/strap_reg_bank.sv
module strap_reg_bank
   import strb_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter logic [1:0] HW_REV    = 2'd1,
   parameter logic [7:0] LOGIC_REV = 8'h23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [1:0]        strap_prod,
   input  logic              strap_eth_sw,
   input  logic              strap_pcie_sw,
   input  logic              strap_redir_en,
   input  logic [2:0]        strap_freq,
   input  logic [6:0]        strap_pll,
   input  logic              jmp_probe,
   input  logic              jmp_skip_srom,
   input  logic              jmp_boot_sock,
   input  logic [3:0]        jmp_module_id,
   input  logic [3:0]        probe_dbg,
   output logic              led_cpu_red,
   output logic              led_cpu_green,
   output logic [3:0]        led_dbg
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x2C");
   end

   logic [NREG-1:0] hit;
   logic [NREG-1:0] wr_hit;
   logic [7:0]      rd_val [NREG];
   logic [7:0]      rd_mux;
   logic [7:0]      pll_q, led_q, scr_q;
   logic            rd_en;

   strb_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));

   assign wr_hit = hit & {NREG{bus_sel & bus_wr}};
   assign rd_en  = bus_sel & ~bus_wr;

   strb_rw_reg #(.W(8), .KEEP(PLL_KEEP)) u_pll (
      .clk(clk), .rst_n(rst_n), .rst_val({1'b0, strap_pll}),
      .we(wr_hit[IDX_PLL]), .wdata(bus_wdata), .q(pll_q)
   );

   strb_rw_reg #(.W(8), .KEEP(8'hFF)) u_scr (
      .clk(clk), .rst_n(rst_n), .rst_val(8'h00),
      .we(wr_hit[IDX_SCR]), .wdata(bus_wdata), .q(scr_q)
   );

   strb_led_ctl #(.N_DBG(4)) u_led (
      .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_LED]), .wdata(bus_wdata),
      .probe(probe_dbg), .q(led_q), .led_red(led_cpu_red),
      .led_green(led_cpu_green), .led_dbg(led_dbg)
   );

   assign rd_val[IDX_PID]  = {strap_prod, 4'b0000, strap_eth_sw, strap_pcie_sw};
   assign rd_val[IDX_HWV]  = {6'b000000, HW_REV};
   assign rd_val[IDX_LOGV] = LOGIC_REV;
   assign rd_val[IDX_PLL]  = pll_q;
   assign rd_val[IDX_HCFG] = {3'b000, strap_redir_en, 1'b0, strap_freq};
   assign rd_val[IDX_JMP]  = {jmp_probe, jmp_skip_srom, jmp_boot_sock, 1'b0, jmp_module_id};
   assign rd_val[IDX_LED]  = led_q;
   assign rd_val[IDX_SCR]  = scr_q;

   always_comb begin
      rd_mux = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (hit[i]) rd_mux = rd_mux | rd_val[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= 8'h00;
      else if (rd_en)
         bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/strb_chk.sv
module strb_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [3:0]        probe_dbg,
   input logic [3:0]        led_dbg,
   input logic              led_cpu_red
);
   localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(8'h0C);
   localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(8'h1C);
   localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'(8'h14);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R2

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_HOLE) |=> bus_rdata == 8'h00); // R12

   AST_PLL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_PLL) |=> !bus_rdata[7]); // R8

   AST_DBG_FOLLOWS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_LED && bus_wdata[4]) |=> led_dbg == probe_dbg); // R10

   AST_DBG_FOLLOWS_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_LED && !bus_wdata[4]) |=> led_dbg == $past(bus_wdata[3:0])); // R10

   AST_RED_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_LED) |=> led_cpu_red == $past(bus_wdata[7])); // R11
endmodule

bind strap_reg_bank strb_chk #(.ADDR_W(ADDR_W)) u_strb_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .probe_dbg(probe_dbg), .led_dbg(led_dbg), .led_cpu_red(led_cpu_red)
);

// File: tb/test_strap_reg_bank.sv
`timescale 1ns/1ps
module test_strap_reg_bank;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       bus_sel = 0, bus_wr = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic [1:0] strap_prod = 2'b10;
   logic       strap_eth_sw = 1, strap_pcie_sw = 0, strap_redir_en = 1;
   logic [2:0] strap_freq = 3'b110;
   logic [6:0] strap_pll = 7'h35;
   logic       jmp_probe = 1, jmp_skip_srom = 0, jmp_boot_sock = 1;
   logic [3:0] jmp_module_id = 4'hA;
   logic [3:0] probe_dbg = 4'h5;
   logic       led_cpu_red, led_cpu_green;
   logic [3:0] led_dbg;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_q = 0;

   always #2.5 clk = ~clk;

   strap_reg_bank i_strap_reg_bank (.*);

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per read strobe seen at an edge
   always @(posedge clk) rd_q <= bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: unexpected read data %02h expected none", bus_rdata);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_sel = 0; bus_wr = 0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(1);
      // R1 reset state
      chk("R1 rdata", bus_rdata, 8'h00);
      chk("R1 lamps", {6'b0, led_cpu_red, led_cpu_green}, 8'h03);
      chk("R1 dbg follows probe", {4'h0, led_dbg}, 8'h05);
      // R3/R4/R5/R6/R7 read-only map, back to back
      rd(8'h00, 8'h82, "R4 identity");
      rd(8'h04, 8'h01, "R5 board rev");
      rd(8'h08, 8'h23, "R5 logic rev");
      rd(8'h10, 8'h16, "R6 config reserved code 110");
      rd(8'h18, 8'hAA, "R7 jumpers");
      rd(8'h1C, 8'hD0, "R9 LED reset");
      rd(8'h2C, 8'h00, "R13 scratch reset");
      idle(1);
      strap_freq = 3'b111; strap_redir_en = 0;
      rd(8'h10, 8'h07, "R6 config code 111");
      // R8 strap latched, then writable
      strap_pll = 7'h00;
      rd(8'h0C, 8'h35, "R8 PLL latched");
      wr(8'h0C, 8'hFF);
      rd(8'h0C, 8'h7F, "R8 PLL written, bit7 zero");
      // R13 scratch
      wr(8'h2C, 8'h5A);
      rd(8'h2C, 8'h5A, "R13 scratch 5A");
      wr(8'h2C, 8'hA5);
      rd(8'h2C, 8'hA5, "R13 scratch A5");
      // R2 hold
      idle(4);
      chk("R2 rdata held", bus_rdata, 8'hA5);
      // R12 ignored writes and holes
      wr(8'h00, 8'h77);
      wr(8'h10, 8'h77);
      wr(8'h14, 8'h77);
      wr(8'h2D, 8'h99);
      wr(8'h2E, 8'h99);
      rd(8'h00, 8'h82, "R12 identity unchanged");
      rd(8'h10, 8'h07, "R12 config unchanged");
      rd(8'h14, 8'h00, "R12 hole 0x14");
      rd(8'h2E, 8'h00, "R12 misaligned 0x2E");
      rd(8'hFC, 8'h00, "R12 unmapped 0xFC");
      rd(8'h2C, 8'hA5, "R12 scratch unchanged");
      // R9/R10/R11 LED
      wr(8'h1C, 8'hFF);
      rd(8'h1C, 8'hDF, "R9 LED bit5 zero");
      idle(1);
      probe_dbg = 4'h3;
      idle(1);
      chk("R10 debug mode probe", {4'h0, led_dbg}, 8'h03);
      wr(8'h1C, 8'h0A);
      idle(1);
      chk("R10 sw mode bits", {4'h0, led_dbg}, 8'h0A);
      chk("R11 lamps off", {6'b0, led_cpu_red, led_cpu_green}, 8'h00);
      probe_dbg = 4'hC;
      idle(1);
      chk("R10 sw mode ignores probe", {4'h0, led_dbg}, 8'h0A);
      wr(8'h1C, 8'h80);
      idle(1);
      chk("R11 red only", {6'b0, led_cpu_red, led_cpu_green}, 8'h02);
      wr(8'h1C, 8'h50);
      idle(1);
      chk("R11 green only", {6'b0, led_cpu_red, led_cpu_green}, 8'h01);
      chk("R10 probe again", {4'h0, led_dbg}, 8'h0C);
      idle(3);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R2: %0d reads unanswered expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule